// File: doc/BRIEF.md
# Slave-Side DMA Byte Mover

This block moves a block of bytes between an external DMA controller and an on-chip buffer RAM. The external controller is the bus master. It drives an active-low acknowledge together with the ordinary write or read strobes. The block never drives a strobe itself. It only raises an active-low request, counts the bytes that are acknowledged, steps a buffer pointer, and reports the end of the block.

The processor sets up a transfer through a small configuration write port. It loads a start address, loads a byte count, and then writes a control word. The control word chooses the direction and sets the go bit. The go bit is not stored: it clears itself when the block completes.

While a block is running, the engine ignores both the processor's configuration writes and any strobes that arrive without acknowledge. When the last byte is acknowledged, the request is released and a one-cycle completion pulse goes to the interrupt logic.

The RAM side is a plain synchronous single-port interface with one cycle of read latency.

Top module: `dma_slave_engine`

## Requirements
- R1: After reset the outputs are in their idle state: `dma_drq_n` is 1, and `done_pulse`, `mem_we`, `mem_re` and `bus_oe` are all 0.
- R2: A control write (`cfg_sel`=2) with bit 0 set, made while idle and with a nonzero count, drives `dma_drq_n` low from the next cycle. The request stays low until the final byte of the block.
- R3: A transfer happens on the first cycle in which the selected strobe is low after being high, while `dma_dack_n` is low. Each transfer moves exactly one byte and lowers the remaining count by one. The block completes after exactly the programmed number of transfers.
- R4: `mem_addr` starts at the address loaded with `cfg_sel`=0. It rises by one per transfer and wraps from 255 to 0. After completion it holds start+count modulo 256.
- R5: For an inbound block (control bit 1 = 0), each transfer asserts `mem_we` for one cycle. In that cycle `mem_wdata` equals `bus_din` and `mem_addr` equals the current buffer address.
- R6: For an outbound block (control bit 1 = 1), `mem_re` is high while the block runs. `bus_oe` is high while `dma_dack_n` and `bus_rd_n` are both low, and `bus_dout` then carries the RAM byte at the current address.
- R7: A strobe made while `dma_dack_n` is high is ignored. It writes no RAM byte and does not change the count or the address.
- R8: From the cycle after the final transfer, `dma_drq_n` is 1 and `done_pulse` is high for exactly one cycle. The go bit has then cleared, so later acknowledged strobes move nothing.
- R9: A go write made while the count is zero raises no request and gives a one-cycle `done_pulse` in the next cycle.
- R10: While a block runs, configuration writes to the count, the address or the control word are ignored.
- R11: The strobe of the direction that was not chosen never causes a transfer, even with acknowledge low.

Configuration encoding: `cfg_sel` 0 loads the address, 1 loads the count, 2 is the control word, and 3 is unused. In the control word, bit 0 is go and bit 1 selects outbound.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write pulse |
| cfg_sel | input | 2 | Configuration target: 0 address, 1 count, 2 control |
| cfg_wdata | input | 8 | Configuration write data |
| dma_drq_n | output | 1 | Active-low data request |
| dma_dack_n | input | 1 | Active-low data acknowledge |
| bus_wr_n | input | 1 | Active-low write strobe from the external master |
| bus_rd_n | input | 1 | Active-low read strobe from the external master |
| bus_din | input | 8 | Data bus into the block |
| bus_dout | output | 8 | Data bus out of the block |
| bus_oe | output | 1 | Output enable for `bus_dout` |
| mem_addr | output | 8 | Buffer RAM address |
| mem_we | output | 1 | Buffer RAM write enable |
| mem_wdata | output | 8 | Buffer RAM write data |
| mem_re | output | 1 | Buffer RAM read enable |
| mem_rdata | input | 8 | Buffer RAM read data, one cycle after the address |
| done_pulse | output | 1 | One-cycle completion event for the interrupt logic |

## Verification
On every cycle, the assertions check the per-transfer steps of count and address, including the pointer wrap. They also check that RAM writes only happen with acknowledge low in an inbound block, that the output enable only appears in an outbound block, and that a running block's state does not move without a transfer. They further check that the request is only held with a nonzero count and is released whenever completion is signalled.

Only the bench's scenarios can show the following. The block ends after exactly the programmed number of bytes. Configuration writes made in the middle of a block do not change that number. The correct bytes reach the right RAM locations and the bus. A zero-count start signals completion at once. The sweep covers start addresses near the wrap point, counts from zero upward, and both directions.

// File: rtl/dma_slv_pkg.sv
package dma_slv_pkg;

  typedef enum logic [1:0] {
    CFG_ADDR  = 2'd0,
    CFG_COUNT = 2'd1,
    CFG_CTRL  = 2'd2,
    CFG_NONE  = 2'd3
  } cfg_sel_e;

  localparam int CTRL_GO_BIT  = 0;
  localparam int CTRL_OUT_BIT = 1;

  typedef struct packed {
    logic load_addr;
    logic load_cnt;
    logic load_ctrl;
    logic go;
    logic dir_out;
  } cfg_cmd_t;

  localparam int STROBE_WR = 0;
  localparam int STROBE_RD = 1;
  localparam int N_STROBES = 2;

endpackage

// File: rtl/dma_cfg_decode.sv
module dma_cfg_decode
  import dma_slv_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic              busy,
  output cfg_cmd_t          cmd
);

  logic accept;
  assign accept = cfg_we & ~busy;

  always_comb begin
    cmd = '0;
    if (accept) begin
      unique case (cfg_sel_e'(cfg_sel))
        CFG_ADDR:  cmd.load_addr = 1'b1;
        CFG_COUNT: cmd.load_cnt  = 1'b1;
        CFG_CTRL: begin
          cmd.load_ctrl = 1'b1;
          cmd.go        = cfg_wdata[CTRL_GO_BIT];
          cmd.dir_out   = cfg_wdata[CTRL_OUT_BIT];
        end
        default: cmd = '0;
      endcase
    end
  end

endmodule

// File: rtl/dma_strobe_edge.sv
module dma_strobe_edge
  import dma_slv_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N_STROBES-1:0] strobe_n,
  input  logic                 dack_n,
  output logic [N_STROBES-1:0] ack_fall
);

  for (genvar g = 0; g < N_STROBES; g++) begin : g_strobe
    logic prev_n;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_n <= 1'b1;
      else        prev_n <= strobe_n[g];
    end
    assign ack_fall[g] = prev_n & ~strobe_n[g] & ~dack_n;
  end

endmodule

// File: rtl/dma_xfer_ctrl.sv
module dma_xfer_ctrl
  import dma_slv_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cfg_cmd_t          cmd,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic              wr_ack,
  input  logic              rd_ack,
  output logic              active_q,
  output logic              dir_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [CNT_W-1:0]  cnt_q,
  output logic              xfer_evt,
  output logic              done_q
);

  function automatic logic [ADDR_W-1:0] addr_next(input logic [ADDR_W-1:0] a);
    return a + ADDR_W'(1);
  endfunction

  function automatic logic [CNT_W-1:0] cnt_next(input logic [CNT_W-1:0] c);
    return c - CNT_W'(1);
  endfunction

  function automatic logic cnt_is_last(input logic [CNT_W-1:0] c);
    return c == CNT_W'(1);
  endfunction

  logic strobe_hit;
  logic start_ok;
  logic start_empty;
  logic last_evt;

  assign strobe_hit  = dir_q ? rd_ack : wr_ack;
  assign xfer_evt    = active_q & strobe_hit;
  assign last_evt    = xfer_evt & cnt_is_last(cnt_q);
  assign start_ok    = cmd.go & (cnt_q != '0);
  assign start_empty = cmd.go & (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      dir_q    <= 1'b0;
      addr_q   <= '0;
      cnt_q    <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= last_evt | start_empty;
      if (cmd.load_addr) addr_q <= ADDR_W'(cfg_wdata);
      if (cmd.load_cnt)  cnt_q  <= CNT_W'(cfg_wdata);
      if (cmd.load_ctrl) dir_q  <= cmd.dir_out;
      if (start_ok)      active_q <= 1'b1;
      if (xfer_evt) begin
        addr_q <= addr_next(addr_q);
        cnt_q  <= cnt_next(cnt_q);
      end
      if (last_evt) active_q <= 1'b0;
    end
  end

endmodule

// File: rtl/dma_slave_engine.sv
module dma_slave_engine
  import dma_slv_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic              dma_drq_n,
  input  logic              dma_dack_n,
  input  logic              bus_wr_n,
  input  logic              bus_rd_n,
  input  logic [DATA_W-1:0] bus_din,
  output logic [DATA_W-1:0] bus_dout,
  output logic              bus_oe,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_re,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              done_pulse
);

  cfg_cmd_t              cmd;
  logic [N_STROBES-1:0]  ack_fall;
  logic                  active_q;
  logic                  dir_q;
  logic [ADDR_W-1:0]     addr_q;
  logic [CNT_W-1:0]      cnt_q;
  logic                  xfer_evt;
  logic                  done_q;

  dma_cfg_decode #(.DATA_W(DATA_W)) u_decode (
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .cfg_wdata (cfg_wdata),
    .busy      (active_q),
    .cmd       (cmd)
  );

  dma_strobe_edge u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe_n ({bus_rd_n, bus_wr_n}),
    .dack_n   (dma_dack_n),
    .ack_fall (ack_fall)
  );

  dma_xfer_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd       (cmd),
    .cfg_wdata (cfg_wdata),
    .wr_ack    (ack_fall[STROBE_WR]),
    .rd_ack    (ack_fall[STROBE_RD]),
    .active_q  (active_q),
    .dir_q     (dir_q),
    .addr_q    (addr_q),
    .cnt_q     (cnt_q),
    .xfer_evt  (xfer_evt),
    .done_q    (done_q)
  );

  assign dma_drq_n  = ~active_q;
  assign done_pulse = done_q;
  assign mem_addr   = addr_q;
  assign mem_we     = xfer_evt & ~dir_q;
  assign mem_wdata  = bus_din;
  assign mem_re     = active_q & dir_q;
  assign bus_dout   = mem_rdata;
  assign bus_oe     = active_q & dir_q & ~dma_dack_n & ~bus_rd_n;

endmodule

// File: rtl/dma_slave_engine_chk.sv
module dma_slave_engine_chk #(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              dma_drq_n,
  input logic              dma_dack_n,
  input logic              done_pulse,
  input logic              mem_we,
  input logic              bus_oe,
  input logic              xfer_evt,
  input logic              active_q,
  input logic              dir_q,
  input logic [ADDR_W-1:0] addr_q,
  input logic [CNT_W-1:0]  cnt_q
);

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_evt |=> cnt_q == $past(cnt_q) - CNT_W'(1)); // R3

  AST_ADDR_STEP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_evt |=> addr_q == $past(addr_q) + ADDR_W'(1)); // R4

  AST_WRITE_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (!dma_dack_n && !dir_q)); // R5

  AST_OE_OUTBOUND_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> (dir_q && active_q && !dma_dack_n)); // R6

  AST_FROZEN_WITHOUT_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && !xfer_evt) |=> ($stable(cnt_q) && $stable(addr_q) && $stable(dir_q))); // R10

  AST_DONE_RELEASES_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |-> dma_drq_n); // R8

  AST_REQ_HAS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    !dma_drq_n |-> cnt_q != '0); // R2

endmodule

bind dma_slave_engine dma_slave_engine_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .dma_drq_n  (dma_drq_n),
  .dma_dack_n (dma_dack_n),
  .done_pulse (done_pulse),
  .mem_we     (mem_we),
  .bus_oe     (bus_oe),
  .xfer_evt   (xfer_evt),
  .active_q   (active_q),
  .dir_q      (dir_q),
  .addr_q     (addr_q),
  .cnt_q      (cnt_q)
);

// File: tb/dma_slave_engine_bench.sv
`timescale 1ns/1ps
module dma_slave_engine_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_sel = 2'd3;
  logic [7:0] cfg_wdata = 8'h00;
  logic       dma_drq_n;
  logic       dma_dack_n = 1'b1;
  logic       bus_wr_n = 1'b1;
  logic       bus_rd_n = 1'b1;
  logic [7:0] bus_din = 8'h00;
  logic [7:0] bus_dout;
  logic       bus_oe;
  logic [7:0] mem_addr;
  logic       mem_we;
  logic [7:0] mem_wdata;
  logic       mem_re;
  logic [7:0] mem_rdata = 8'h00;
  logic       done_pulse;

  logic [7:0] ram [256];
  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  dma_slave_engine u_dma_slave_engine (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .dma_drq_n(dma_drq_n), .dma_dack_n(dma_dack_n), .bus_wr_n(bus_wr_n), .bus_rd_n(bus_rd_n),
    .bus_din(bus_din), .bus_dout(bus_dout), .bus_oe(bus_oe), .mem_addr(mem_addr),
    .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_re(mem_re), .mem_rdata(mem_rdata),
    .done_pulse(done_pulse)
  );

  always @(posedge clk) begin
    if (mem_we) ram[mem_addr] <= mem_wdata;
    if (mem_re) mem_rdata <= ram[mem_addr];
  end

  function automatic logic [7:0] fill_pat(input int a);
    return 8'((a * 37 + 11) ^ 8'h5A);
  endfunction

  function automatic logic [7:0] din_pat(input int s, input int i, input int n);
    return 8'(s * 3 + i * 29 + n + 1);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0; cfg_sel = 2'd3;
  endtask

  // one strobe pulse; wr selects the write strobe, ack drives acknowledge
  task automatic pulse(input bit wr, input bit ack, input logic [7:0] d,
                       output logic we_seen, output logic oe_seen, output logic [7:0] dout_seen,
                       output logic [7:0] addr_seen);
    @(negedge clk);
    dma_dack_n = ~ack; bus_din = d;
    if (wr) bus_wr_n = 1'b0; else bus_rd_n = 1'b0;
    #1;
    we_seen = mem_we; oe_seen = bus_oe; dout_seen = bus_dout; addr_seen = mem_addr;
    @(negedge clk);
    bus_wr_n = 1'b1; bus_rd_n = 1'b1; dma_dack_n = 1'b1;
    #1;
  endtask

  task automatic run_block(input int start, input int n, input bit outb);
    logic we_s, oe_s;
    logic [7:0] do_s, ad_s;
    cfg_write(2'd0, 8'(start));
    cfg_write(2'd1, 8'(n));
    cfg_write(2'd2, {6'd0, outb, 1'b1});
    #1;
    if (n == 0) begin
      chk(dma_drq_n == 1'b1, "R9 no request for zero count", dma_drq_n, 1);
      chk(done_pulse == 1'b1, "R9 immediate done", done_pulse, 1);
      @(negedge clk); #1;
      chk(done_pulse == 1'b0, "R9 done one cycle", done_pulse, 0);
      return;
    end
    chk(dma_drq_n == 1'b0, "R2 request asserted", dma_drq_n, 0);
    // strobe without acknowledge: ignored (R7)
    pulse(!outb, 1'b0, 8'hEE, we_s, oe_s, do_s, ad_s);
    chk(we_s == 1'b0 && oe_s == 1'b0, "R7 unacked strobe ignored", {we_s, oe_s}, 0);
    chk(mem_addr == 8'(start), "R7 address unchanged", mem_addr, 8'(start));
    // strobe of the other direction with acknowledge: ignored (R11)
    pulse(outb, 1'b1, 8'hDD, we_s, oe_s, do_s, ad_s);
    chk(we_s == 1'b0, "R11 wrong strobe no write", we_s, 0);
    chk(mem_addr == 8'(start), "R11 address unchanged", mem_addr, 8'(start));
    for (int i = 0; i < n; i++) begin
      int ea = (start + i) % 256;
      if (i == 1) begin
        cfg_write(2'd1, 8'd1);
        cfg_write(2'd0, 8'h33);
        cfg_write(2'd2, 8'h00);
        #1;
        chk(mem_addr == 8'(ea), "R10 address write ignored", mem_addr, ea);
        chk(dma_drq_n == 1'b0, "R10 control write ignored", dma_drq_n, 0);
      end
      pulse(!outb, 1'b1, din_pat(start, i, n), we_s, oe_s, do_s, ad_s);
      chk(ad_s == 8'(ea), "R4 address per byte", ad_s, ea);
      if (outb) begin
        chk(oe_s == 1'b1, "R6 output enable", oe_s, 1);
        chk(do_s == fill_pat(ea), "R6 read data", do_s, fill_pat(ea));
      end else begin
        chk(we_s == 1'b1, "R5 write enable", we_s, 1);
      end
      if (i == n - 1) begin
        chk(dma_drq_n == 1'b1, "R8 request released", dma_drq_n, 1);
        chk(done_pulse == 1'b1, "R8 done pulse", done_pulse, 1);
      end else begin
        chk(dma_drq_n == 1'b0 && done_pulse == 1'b0, "R3 block not over early", {dma_drq_n, done_pulse}, 0);
      end
    end
    @(negedge clk); #1;
    chk(done_pulse == 1'b0, "R8 done one cycle", done_pulse, 0);
    chk(mem_addr == 8'((start + n) % 256), "R4 final address wraps", mem_addr, (start + n) % 256);
    chk(mem_re == 1'b0, "R8 read enable off", mem_re, 0);
    pulse(!outb, 1'b1, 8'hA5, we_s, oe_s, do_s, ad_s);
    chk(we_s == 1'b0 && oe_s == 1'b0 && dma_drq_n == 1'b1, "R8 go bit cleared", {we_s, oe_s}, 0);
    chk(mem_addr == 8'((start + n) % 256), "R8 no move after done", mem_addr, (start + n) % 256);
    if (!outb) begin
      for (int i = 0; i < n; i++) begin
        int ea = (start + i) % 256;
        chk(ram[ea] == din_pat(start, i, n), "R5 byte stored", ram[ea], din_pat(start, i, n));
      end
    end
  endtask

  initial begin
    #(5.0 * 200000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int starts [3] = '{0, 126, 253};
    for (int a = 0; a < 256; a++) ram[a] = fill_pat(a);
    repeat (3) @(negedge clk);
    #1;
    chk(dma_drq_n == 1'b1 && done_pulse == 1'b0, "R1 reset request/done", {dma_drq_n, done_pulse}, 2);
    chk(mem_we == 1'b0 && mem_re == 1'b0 && bus_oe == 1'b0, "R1 reset memory/bus", {mem_we, mem_re, bus_oe}, 0);
    rst_n = 1'b1;
    for (int d = 1; d >= 0; d--) begin
      for (int s = 0; s < 3; s++) begin
        for (int n = 0; n <= 5; n++) begin
          run_block(starts[s], n, d[0]);
        end
      end
    end
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule